// File: doc/BRIEF.md
# RS-485 Nine-Bit Multidrop Transmitter

This block serialises characters onto a half-duplex RS-485 bus that is shared by one master and many slaves. Every character carries eight data bits and a ninth tag bit that sits where a parity bit would normally go. The tag is forced rather than computed. A one marks a station address and a zero marks a payload byte, so the slaves can pick out the address characters. The bit rate comes from an external one-cycle enable pulse, `bit_tick`, and each bit lasts one tick interval.

The block can also own the transceiver's driver-enable line. With automatic direction on, the block raises `dir` one bit time ahead of the first start bit and holds it across any run of back-to-back characters. It drops `dir` when the stop bit of the last waiting character ends. With automatic direction off, `dir` is a plain copy of a software-chosen level. Loopback takes precedence over both: the bus stays idle and undriven, and the serial stream goes to an internal return output. A one-entry holding register behind a valid/ready handshake lets the next character be queued while the current one is on the wire.

Top module: `rs485_tx9`

## Requirements
- R1: A frame is a start bit (0), eight data bits least significant first, the tag bit, and a stop bit (1). Each bit lasts one `bit_tick` interval, and the line rests at 1 between frames.
- R2: The tag bit is 1 when the character was offered with `tx_addr`=1 (address) and 0 when offered with `tx_addr`=0 (data).
- R3: A character is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the cycle after acceptance until that character moves into the serialiser at a tick edge, and characters are sent in acceptance order without loss.
- R4: With `auto_dir_en`=1 and `loopback`=0, starting from idle, `dir` becomes 1 exactly one bit interval before the start bit begins.
- R5: With automatic direction active, `dir` stays 1 through the last stop bit and returns to 0 at the tick edge that ends that stop bit when no character is waiting.
- R6: A character accepted before the current stop bit ends is sent starting at the very next bit slot with no idle bit, and `dir` stays 1 without a gap across the whole run.
- R7: With `auto_dir_en`=1 and `loopback`=0, `manual_dir` has no effect on `dir`.
- R8: With `loopback`=1, `dir` is 0 and `txd` stays 1 whatever `auto_dir_en` and `manual_dir` are, and the frame of R1 appears on `lb_txd`. With `loopback`=0, `lb_txd` rests at 1.
- R9: With `auto_dir_en`=0 and `loopback`=0, `dir` equals `manual_dir`, and a character offered to an idle line begins its start bit at the first tick edge after acceptance, with no lead bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit interval |
| tx_data | input | 8 | Character to send |
| tx_addr | input | 1 | 1 = address character, 0 = data character |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Holding register can take a character |
| auto_dir_en | input | 1 | Hardware drives the direction output |
| manual_dir | input | 1 | Direction level when automatic control is off |
| loopback | input | 1 | Route the serial stream internally |
| txd | output | 1 | Serial bus line |
| dir | output | 1 | Transceiver driver enable |
| lb_txd | output | 1 | Internal loopback copy of the serial stream |

## Verification
The line and the direction output both change on the clock edge where `bit_tick` is high. A start bit therefore appears one cycle after that edge, and the bench samples each bit two and a half cycles into its four-cycle interval, counted from the falling clock edge where the start bit is first seen. The direction lead is measured as the number of falling edges with `dir` high and the line idle before the start, and must equal one tick interval. The release of `dir` is checked on the falling edge before and the falling edge after the tick that closes the stop bit. The ready drop is checked on the first falling edge after acceptance. The no-lead start in manual mode must fall within one tick interval of acceptance.

// File: rtl/rs485_tx9_pkg.sv
package rs485_tx9_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LEAD = 2'd1,
    SQ_SEND = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tx9_hold.sv
module tx9_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_tag
);
  logic              full_d;
  logic [DATA_W-1:0] data_d;
  logic              tag_d;
  logic              data_en;

  always_comb begin
    full_d  = full;
    data_en = push && !full;
    data_d  = push_data;
    tag_d   = push_tag;
    if (pop)     full_d = 1'b0;
    if (data_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hold_data <= '0;
      hold_tag  <= 1'b0;
    end else if (data_en) begin
      hold_data <= data_d;
      hold_tag  <= tag_d;
    end
  end

  // R3
  hold_accept_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (push && !full && !pop) |=> full);
endmodule

// File: rtl/tx9_shifter.sv
module tx9_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_tag,
  output logic              line,
  output logic              busy,
  output logic              on_stop
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_d;

  always_comb begin
    frame_d = frame_q;
    cnt_d   = cnt_q;
    busy_d  = busy;
    if (tick) begin
      if (load) begin
        frame_d = {1'b1, ld_tag, ld_data, 1'b0};
        cnt_d   = '0;
        busy_d  = 1'b1;
      end else if (busy) begin
        frame_d = {1'b1, frame_q[FRAME_W-1:1]};
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      frame_q <= '1;
      cnt_q   <= '0;
      busy    <= 1'b0;
    end else if (tick) begin
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
      busy    <= busy_d;
    end
  end

  assign line    = frame_q[0];
  assign on_stop = busy && (cnt_q == LAST);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> line);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && load) |=> !line);
endmodule

// File: rtl/tx9_seq.sv
module tx9_seq
  import rs485_tx9_pkg::*;
(
  input  logic clk,
  input  logic rst_q,
  input  logic tick,
  input  logic hold_full,
  input  logic use_lead,
  input  logic on_stop,
  output logic load,
  output logic dir_auto
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    if (tick) begin
      case (st_q)
        SQ_IDLE: if (hold_full) begin
          if (use_lead) st_d = SQ_LEAD;
          else begin
            st_d = SQ_SEND;
            load = 1'b1;
          end
        end
        SQ_LEAD: begin
          st_d = SQ_SEND;
          load = 1'b1;
        end
        SQ_SEND: if (on_stop) begin
          if (hold_full) load = 1'b1;
          else           st_d = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) st_q <= SQ_IDLE;
    else if (tick) st_q <= st_d;
  end

  assign dir_auto = (st_q != SQ_IDLE);

  // R4
  lead_then_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == SQ_LEAD && tick) |=> (st_q == SQ_SEND));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && on_stop && !hold_full && st_q == SQ_SEND) |=> !dir_auto);
endmodule

// File: rtl/rs485_tx9.sv
module rs485_tx9 #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              auto_dir_en,
  input  logic              manual_dir,
  input  logic              loopback,
  output logic              txd,
  output logic              dir,
  output logic              lb_txd
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic              full, load, line, busy, on_stop, dir_auto, use_lead;
  logic [DATA_W-1:0] hold_data;
  logic              hold_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign use_lead = auto_dir_en && !loopback;

  tx9_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_q     (rst_q),
    .push      (tx_valid),
    .push_data (tx_data),
    .push_tag  (tx_addr),
    .pop       (load),
    .full      (full),
    .hold_data (hold_data),
    .hold_tag  (hold_tag)
  );

  tx9_seq u_seq (
    .clk       (clk),
    .rst_q     (rst_q),
    .tick      (bit_tick),
    .hold_full (full),
    .use_lead  (use_lead),
    .on_stop   (on_stop),
    .load      (load),
    .dir_auto  (dir_auto)
  );

  tx9_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_q   (rst_q),
    .tick    (bit_tick),
    .load    (load),
    .ld_data (hold_data),
    .ld_tag  (hold_tag),
    .line    (line),
    .busy    (busy),
    .on_stop (on_stop)
  );

  always_comb begin
    tx_ready = !full;
    txd      = loopback ? 1'b1 : line;
    lb_txd   = loopback ? line : 1'b1;
    if (loopback)         dir = 1'b0;
    else if (auto_dir_en) dir = dir_auto;
    else                  dir = manual_dir;
  end

  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (use_lead && !line) |-> dir);
  // R8
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    loopback |-> (txd && !dir));
  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && tx_ready && !load) |=> !tx_ready);
  // R6
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_tick && on_stop && full) |=> busy);
endmodule

// File: tb/test_rs485_tx9.sv
module test_rs485_tx9;
  localparam int TICK_DIV = 4;

  logic       clk, rst_n, bit_tick;
  logic [7:0] tx_data;
  logic       tx_addr, tx_valid, tx_ready;
  logic       auto_dir_en, manual_dir, loopback;
  logic       txd, dir, lb_txd;

  int n_chk, n_fail, gap_cnt, lb_bad;
  bit in_burst, in_loop, done;

  rs485_tx9 i_rs485_tx9 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .tx_data(tx_data), .tx_addr(tx_addr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .auto_dir_en(auto_dir_en),
    .manual_dir(manual_dir), .loopback(loopback),
    .txd(txd), .dir(dir), .lb_txd(lb_txd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    bit_tick = 1'b0;
    forever begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        bit_tick = (k == TICK_DIV - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (in_burst && !dir) gap_cnt++;
    if (in_loop && (dir || !txd)) lb_bad++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic send(input logic [7:0] d, input logic a);
    @(negedge clk);
    tx_data  = d;
    tx_addr  = a;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  function automatic logic [10:0] frame_of(input logic [7:0] d, input logic a);
    return {1'b1, a, d, 1'b0};
  endfunction

  task automatic grab(input bit use_lb, output logic [10:0] bits);
    int t = 0;
    while ((use_lb ? lb_txd : txd) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    @(negedge clk);
    for (int b = 0; b < 11; b++) begin
      bits[b] = use_lb ? lb_txd : txd;
      if (b < 10) repeat (TICK_DIV) @(negedge clk);
    end
  endtask

  initial begin
    logic [10:0] got;
    int n;
    n_chk = 0; n_fail = 0; gap_cnt = 0; lb_bad = 0;
    in_burst = 0; in_loop = 0; done = 0;
    tx_data = 8'h00; tx_addr = 1'b0; tx_valid = 1'b0;
    auto_dir_en = 1'b1; manual_dir = 1'b0; loopback = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R5 reset dir", dir, 0);
    check("R3 reset ready", tx_ready, 1);
    check("R8 reset lb_txd", lb_txd, 1);

    // R7: manual level ignored under automatic control
    manual_dir = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 idle dir with manual_dir=1", dir, 0);
    manual_dir = 1'b0;

    // R4, R3, R5: single address frame, auto direction
    wait (bit_tick == 1'b1);
    @(negedge clk);
    fork
      send(8'h3C, 1'b1);
      begin
        @(posedge clk);
        while (!(tx_valid && tx_ready)) @(posedge clk);
        @(negedge clk);
        check("R3 ready low after accept", tx_ready, 0);
      end
      begin
        n = 0;
        while (txd) begin
          @(negedge clk);
          if (dir && txd) n++;
        end
        check("R4 lead cycles", n, TICK_DIV);
      end
    join
    repeat (2) @(negedge clk);
    got = 11'h7FF;
    for (int b = 1; b < 11; b++) begin
      repeat (TICK_DIV) @(negedge clk);
      got[b] = txd;
    end
    got[0] = 1'b0;
    check("R2 address frame", got, frame_of(8'h3C, 1'b1));
    @(negedge clk);
    check("R5 dir held to stop end", dir, 1);
    @(negedge clk);
    check("R5 dir released", dir, 0);
    check("R1 idle after stop", txd, 1);

    // R1, R2, R3, R6: back-to-back sweep of every byte with both tags
    repeat (20) @(negedge clk);
    fork
      for (int i = 0; i < 512; i++) send(i[7:0], i[8]);
      begin
        for (int i = 0; i < 512; i++) begin
          grab(1'b0, got);
          if (i == 0) in_burst = 1'b1;
          check(i[8] ? "R2 sweep address frame" : "R1 sweep data frame",
                got, frame_of(i[7:0], i[8]));
        end
        in_burst = 1'b0;
        @(negedge clk);
        check("R5 dir high end of burst", dir, 1);
        @(negedge clk);
        check("R5 dir low after burst", dir, 0);
      end
    join
    check("R6 dir gap cycles in burst", gap_cnt, 0);

    // R9: manual direction, no lead
    auto_dir_en = 1'b0;
    manual_dir = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 manual dir=1", dir, 1);
    manual_dir = 1'b0;
    @(negedge clk);
    check("R9 manual dir=0", dir, 0);
    send(8'hA5, 1'b0);
    n = 0;
    while (txd && n < 50) begin
      n++;
      @(negedge clk);
    end
    check("R9 start within one tick", (n <= TICK_DIV) ? 1 : 0, 1);
    check("R9 dir follows manual in frame", dir, 0);
    got[0] = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 1; b < 11; b++) begin
      repeat (TICK_DIV) @(negedge clk);
      got[b] = txd;
    end
    check("R2 data frame manual", got, frame_of(8'hA5, 1'b0));
    repeat (8) @(negedge clk);

    // R8: loopback with auto and manual both requesting drive
    auto_dir_en = 1'b1;
    manual_dir = 1'b1;
    loopback = 1'b1;
    repeat (2) @(negedge clk);
    in_loop = 1'b1;
    fork
      send(8'h96, 1'b1);
      grab(1'b1, got);
    join
    repeat (8) @(negedge clk);
    in_loop = 1'b0;
    check("R8 loopback frame", got, frame_of(8'h96, 1'b1));
    check("R8 bus quiet in loopback", lb_bad, 0);
    loopback = 1'b0;
    manual_dir = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 lb_txd idle out of loopback", lb_txd, 1);

    finish_run();
  end
endmodule